// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register Block

This block is the software-visible register front end of an interrupt redirection controller. Software sees only two 32-bit locations. One is a select register that holds an 8-bit index. The other is a data window that reads or writes whichever internal register the index points at. Behind the window sit four kinds of register:

- an identifier register;
- a constant version register;
- an arbitration register that always reads zero;
- a table of 64-bit redirection entries, one for each interrupt input pin.

Each 64-bit entry is reached as two 32-bit halves on neighbouring indices.

The bus is a plain synchronous strobe interface with registered read data. The whole table is driven out in parallel to the interrupt servicing logic. A one-cycle rescan pulse tells that logic that an entry has changed, so it must evaluate pending interrupts again. Bridging to a system bus protocol and the delivery of interrupts belong to other blocks.

Top module: `irq_redir_regs`

## Requirements
- R1: After reset the select register and the identifier are zero, and every table entry equals 0x0000_0000_0001_0000 (mask bit 16 set), so the low half reads 0x0001_0000 and the high half reads zero.
- R2: A write to offset 0x00 stores data bits 7:0 as the select index, and a read at offset 0x00 returns that index zero-extended to 32 bits.
- R3: Only address bits 7:0 are decoded, so upper address bits have no effect. A read at any offset other than 0x00 and 0x10 returns zero. A write at any such offset changes nothing.
- R4: Through the window, index 0x00 reads the 8-bit identifier in bits 31:24 with all other bits zero. A window write at index 0x00 updates only that field, taken from data bits 31:24.
- R5: Index 0x01 reads 0x11 in bits 7:0 and the highest entry number (entry count minus one) in bits 23:16, with all other bits zero. That is 0x0017_0011 for 24 entries. Writes to index 0x01 are ignored.
- R6: Index 0x02 always reads zero, and writes to it are ignored.
- R7: Index 0x10+2n reaches bits 31:0 of entry n, and index 0x11+2n reaches bits 63:32 of entry n. A write replaces only the addressed half. The table output carries entry n on bits 64n+63 down to 64n.
- R8: Window indices 0x03 to 0x0F, and indices from 0x10 plus twice the entry count up to 0xFF, read zero. Writes to them change no entry and no identifier.
- R9: The rescan output pulses high for exactly the one cycle after each window write to a table entry index, and stays low after every other access.
- R10: Read data appears on the cycle after the read strobe. It holds its value until the next read strobe, whatever writes happen in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| entries_o | output | 64*NUM_ENTRIES | All redirection entries, entry n on bits 64n+63:64n |
| rescan_o | output | 1 | One-cycle pulse after a table entry write |

## Verification
A wrong select index or a faulty half decode sends a window access to the wrong register. That shows on the first later read, one cycle after its strobe, and at once on the parallel table output, so a write to one half can be caught corrupting a neighbour. A bad reset value or a lost mask bit appears on the table output in the first cycle after reset. A mistimed rescan shows as a pulse that is missing, doubled or spurious in the cycle just after the write. Sweeping every select value, every entry half and every unmapped index compares each of these against an arithmetic model.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ENTRY_W = 64;
  localparam int unsigned SEL_W = 8;

  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  localparam logic [SEL_W-1:0] IDX_ID = 8'h00;
  localparam logic [SEL_W-1:0] IDX_VER = 8'h01;
  localparam logic [SEL_W-1:0] IDX_ARB = 8'h02;
  localparam logic [SEL_W-1:0] IDX_TBL = 8'h10;

  localparam logic [7:0] VERSION_CODE = 8'h11;
  localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_TBL
  } tgt_e;

  typedef struct packed {
    tgt_e             tgt;
    logic             hi;
    logic [SEL_W-1:0] ent;
  } sel_dec_t;
endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24
) (
  input  logic [SEL_W-1:0] sel,
  output sel_dec_t         dec
);
  localparam int unsigned SPAN = 2 * NUM_ENTRIES;

  logic [SEL_W:0] rel;

  always_comb begin
    rel = {1'b0, sel} - {1'b0, IDX_TBL};
    dec = '{tgt: TGT_NONE, hi: 1'b0, ent: '0};
    if (sel == IDX_ID) begin
      dec.tgt = TGT_ID;
    end else if (sel == IDX_VER) begin
      dec.tgt = TGT_VER;
    end else if (sel == IDX_ARB) begin
      dec.tgt = TGT_ARB;
    end else if (sel >= IDX_TBL && 32'(rel) < SPAN) begin
      dec.tgt = TGT_TBL;
      dec.hi  = rel[0];
      dec.ent = rel[SEL_W:1];
    end
  end
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           wr_hi,
  input  logic [SEL_W-1:0]               wr_ent,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_ENTRIES*ENTRY_W-1:0] entries
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_ent == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        entries[g*ENTRY_W +: ENTRY_W] <= ENTRY_RST;
      end else if (hit) begin
        if (wr_hi) begin
          entries[g*ENTRY_W+DATA_W +: DATA_W] <= wr_data;
        end else begin
          entries[g*ENTRY_W +: DATA_W] <= wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/irq_redir_rdmux.sv
module irq_redir_rdmux
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_en,
  input  logic [7:0]                     ofs,
  input  logic [SEL_W-1:0]               sel,
  input  sel_dec_t                       dec,
  input  logic [7:0]                     id,
  input  logic [NUM_ENTRIES*ENTRY_W-1:0] entries,
  output logic [DATA_W-1:0]              rdata
);
  localparam logic [7:0] MAX_ENT = 8'(NUM_ENTRIES - 1);
  localparam logic [DATA_W-1:0] VER_WORD = {8'h00, MAX_ENT, 8'h00, VERSION_CODE};

  logic [ENTRY_W-1:0] ent_pick;
  logic [DATA_W-1:0]  win_val;
  logic [DATA_W-1:0]  nxt;

  always_comb begin
    ent_pick = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (dec.ent == SEL_W'(i)) ent_pick = entries[i*ENTRY_W +: ENTRY_W];
    end
  end

  always_comb begin
    unique case (dec.tgt)
      TGT_ID:  win_val = {id, 24'h0};
      TGT_VER: win_val = VER_WORD;
      TGT_TBL: win_val = dec.hi ? ent_pick[ENTRY_W-1:DATA_W] : ent_pick[DATA_W-1:0];
      default: win_val = '0;
    endcase
  end

  always_comb begin
    if (ofs == OFS_SEL)      nxt = {{(DATA_W-SEL_W){1'b0}}, sel};
    else if (ofs == OFS_WIN) nxt = win_val;
    else                     nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= nxt;
  end
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NUM_ENTRIES*ENTRY_W-1:0] entries_o,
  output logic                           rescan_o
);
  logic [7:0]       ofs;
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       id_q;
  sel_dec_t         dec;
  logic             win_wr;
  logic             tbl_wr;

  assign ofs    = bus_addr[7:0];
  assign win_wr = bus_wr && (ofs == OFS_WIN);
  assign tbl_wr = win_wr && (dec.tgt == TGT_TBL);

  irq_redir_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_dec (
    .sel (sel_q),
    .dec (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      id_q     <= '0;
      rescan_o <= 1'b0;
    end else begin
      if (bus_wr && ofs == OFS_SEL) sel_q <= bus_wdata[SEL_W-1:0];
      if (win_wr && dec.tgt == TGT_ID) id_q <= bus_wdata[31:24];
      rescan_o <= tbl_wr;
    end
  end

  irq_redir_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_wr),
    .wr_hi   (dec.hi),
    .wr_ent  (dec.ent),
    .wr_data (bus_wdata),
    .entries (entries_o)
  );

  irq_redir_rdmux #(.NUM_ENTRIES(NUM_ENTRIES)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd),
    .ofs     (ofs),
    .sel     (sel_q),
    .dec     (dec),
    .id      (id_q),
    .entries (entries_o),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/irq_redir_regs_chk.sv
module irq_redir_regs_chk #(
  parameter int unsigned NUM_ENTRIES = 24,
  parameter int unsigned ADDR_W = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [31:0]               bus_rdata,
  input logic [NUM_ENTRIES*64-1:0] entries_o,
  input logic                      rescan_o,
  input logic [7:0]                sel_q
);
  localparam logic [8:0] TBL_END = 9'(16 + 2 * NUM_ENTRIES);
  localparam logic [31:0] VER_EXP = 32'h11 | (32'(NUM_ENTRIES - 1) << 16);

  logic win, tbl_sel;
  assign win     = bus_addr[7:0] == 8'h10;
  assign tbl_sel = sel_q >= 8'h10 && {1'b0, sel_q} < TBL_END;

  p_rescan_src_r9: assert property (@(posedge clk) disable iff (rst)
    rescan_o |-> $past(bus_wr && win && tbl_sel));

  p_tbl_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> $stable(entries_o));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));

  p_ver_word_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && win && sel_q == 8'h01) |=> bus_rdata == VER_EXP);

  p_arb_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && win && sel_q == 8'h02) |=> bus_rdata == 32'h0);

  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !win && bus_addr[7:0] != 8'h00) |=> bus_rdata == 32'h0);
endmodule

bind irq_redir_regs irq_redir_regs_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .entries_o (entries_o),
  .rescan_o  (rescan_o),
  .sel_q     (sel_q)
);

// File: tb/sim_irq_redir_regs.sv
`timescale 1ns/1ps
module sim_irq_redir_regs;
  localparam int N = 24;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N*64-1:0] entries_o;
  logic          rescan_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [63:0] exp_tbl [N];
  logic [7:0]  exp_id;

  always #10 clk = ~clk;

  irq_redir_regs #(.NUM_ENTRIES(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entries_o(entries_o), .rescan_o(rescan_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] q);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    q = bus_rdata;
  endtask

  task automatic check_table(input string req);
    for (int n = 0; n < N; n++) check(req, entries_o[n*64 +: 64], exp_tbl[n]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    logic [31:0] lo, hi;
    for (int n = 0; n < N; n++) exp_tbl[n] = 64'h0000_0000_0001_0000;
    exp_id = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rescan", {63'b0, rescan_o}, 64'h0);
    check_table("R1 table");
    rd(12'h000, q); check("R1 select", {32'b0, q}, 64'h0);
    rd(12'h010, q); check("R1 id", {32'b0, q}, 64'h0);
    wr(12'h000, 32'h10);
    rd(12'h010, q); check("R1 entry0 lo", {32'b0, q}, 64'h0001_0000);
    wr(12'h000, 32'h11);
    rd(12'h010, q); check("R1 entry0 hi", {32'b0, q}, 64'h0);

    // R2 select sweep
    for (int v = 0; v < 256; v++) begin
      wr(12'h000, {24'hABCDEF, 8'(v)});
      rd(12'h000, q);
      check("R2 select", {32'b0, q}, 64'(v));
    end

    // R3 upper address bits ignored, other offsets dead
    wr(12'h700, 32'h05);
    rd(12'h300, q); check("R3 upper bits", {32'b0, q}, 64'h05);
    wr(12'h004, 32'hFF);
    rd(12'h000, q); check("R3 write offset 04", {32'b0, q}, 64'h05);
    rd(12'h004, q); check("R3 read offset 04", {32'b0, q}, 64'h0);
    rd(12'h014, q); check("R3 read offset 14", {32'b0, q}, 64'h0);
    wr(12'h000, 32'h10);
    wr(12'h090, 32'h1234_5678);
    check("R3 no rescan", {63'b0, rescan_o}, 64'h0);
    check_table("R3 table");

    // R4 identifier
    wr(12'h000, 32'h00);
    wr(12'h010, 32'hA512_3456); exp_id = 8'hA5;
    check("R9 id no rescan", {63'b0, rescan_o}, 64'h0);
    rd(12'h010, q); check("R4 id", {32'b0, q}, {32'b0, exp_id, 24'h0});
    wr(12'hF10, 32'h3C00_0000); exp_id = 8'h3C;
    rd(12'h010, q); check("R4 id upper addr", {32'b0, q}, 64'h3C00_0000);

    // R5 version
    wr(12'h000, 32'h01);
    rd(12'h010, q); check("R5 version", {32'b0, q}, 64'(32'h11 | ((N - 1) << 16)));
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, q); check("R5 version after write", {32'b0, q}, 64'h0017_0011);

    // R10 read data holds
    repeat (3) @(negedge clk);
    check("R10 hold idle", {32'b0, bus_rdata}, 64'h0017_0011);
    wr(12'h004, 32'h0);
    check("R10 hold across write", {32'b0, bus_rdata}, 64'h0017_0011);

    // R6 arbitration
    wr(12'h000, 32'h02);
    rd(12'h010, q); check("R6 arb", {32'b0, q}, 64'h0);
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, q); check("R6 arb after write", {32'b0, q}, 64'h0);

    // R7 and R9 table sweep
    for (int n = 0; n < N; n++) begin
      lo = 32'h1000_0000 + n * 32'h0101_0101;
      hi = ~lo ^ 32'(n << 8);
      wr(12'h000, 32'(16 + 2 * n));
      wr(12'h010, lo); exp_tbl[n][31:0] = lo;
      check("R9 pulse lo", {63'b0, rescan_o}, 64'h1);
      @(negedge clk);
      check("R9 pulse ends", {63'b0, rescan_o}, 64'h0);
      wr(12'h000, 32'(17 + 2 * n));
      check("R9 select no pulse", {63'b0, rescan_o}, 64'h0);
      wr(12'h010, hi); exp_tbl[n][63:32] = hi;
      check("R9 pulse hi", {63'b0, rescan_o}, 64'h1);
      rd(12'h010, q); check("R7 read hi", {32'b0, q}, {32'b0, hi});
      check("R9 read no pulse", {63'b0, rescan_o}, 64'h0);
      wr(12'h000, 32'(16 + 2 * n));
      rd(12'h010, q); check("R7 read lo", {32'b0, q}, {32'b0, lo});
      wr(12'h010, 32'h0001_0000 ^ 32'(n)); exp_tbl[n][31:0] = 32'h0001_0000 ^ 32'(n);
      check_table("R7 half write");
    end

    // R8 unmapped window indices
    for (int v = 3; v < 256; v++) begin
      if (v >= 16 && v < 16 + 2 * N) continue;
      wr(12'h000, 32'(v));
      wr(12'h010, 32'hDEAD_BEEF);
      check("R8 no rescan", {63'b0, rescan_o}, 64'h0);
      rd(12'h010, q); check("R8 read zero", {32'b0, q}, 64'h0);
    end
    check_table("R8 table unchanged");
    wr(12'h000, 32'h00);
    rd(12'h010, q); check("R8 id unchanged", {32'b0, q}, {32'b0, exp_id, 24'h0});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule